// File: doc/BRIEF.md
# Row-Hit-Aware DRAM Request Scheduler

This block sits between the memory clients and the DRAM command sequencer. It holds a small pool of pending requests, each tagged with a bank, row, column and a read/write flag. Every cycle it offers one request on its output port. The choice depends on which row each bank currently has open and on the direction of the request it handed out last. The sequencer enforces device timing. This block only decides the order.

Requests arrive on a valid/ready port and leave on a second valid/ready port. An input bus reports, for every bank, whether a row is open and which row it is. The choice works through a stack of rules:

1. A request that has waited too long goes first.
2. Otherwise, a request that hits the open row of its bank ranks higher.
3. Next comes a request in the same direction as the last one handed out.
4. Next, a read ranks above a write.
5. Ties go to the oldest request.

A read never passes an older queued write to the same bank, row and column.

Top module: `dram_req_sched`

## Requirements
- R1: After reset the pool is empty: `deq_valid_o` is 0 and `enq_ready_o` is 1.
- R2: `enq_ready_o` is 0 exactly when DEPTH requests are held. An enqueue offered while it is 0 is dropped and leaves the pool unchanged.
- R3: A request counts as a hit when `open_vld_i[bank]` is 1 and row slice `bank` of `open_row_i` (bits `bank*ROW_W` upward) equals its row. A hit outranks a miss unless the miss is starved.
- R4: Among requests with equal starvation and hit status, one whose write flag equals that of the last dequeued request ranks higher. Before the first dequeue, the last direction counts as read.
- R5: Among requests still equal after R3 and R4, a read (`write` = 0) ranks above a write.
- R6: Among requests of equal rank, the one enqueued earliest is chosen.
- R7: A request's age starts at 0 on enqueue and rises by one at every clock edge it stays queued. Once its age reaches AGE_LIMIT, it outranks every request that is not also starved.
- R8: A read whose bank, row and column all match an older queued write is not offered until that write has left.
- R9: `deq_valid_o` is 1 whenever the pool is non-empty. A request leaves only on a clock edge where `deq_valid_o` and `deq_ready_i` are both 1. The dequeue fields carry the chosen request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | New request offered |
| enq_ready_o | output | 1 | Pool has a free slot |
| enq_bank_i | input | $clog2(NUM_BANKS) | Bank of new request |
| enq_row_i | input | ROW_W | Row of new request |
| enq_col_i | input | COL_W | Column of new request |
| enq_write_i | input | 1 | 1 = write, 0 = read |
| deq_valid_o | output | 1 | A request is offered |
| deq_ready_i | input | 1 | Sequencer takes the offered request |
| deq_bank_o | output | $clog2(NUM_BANKS) | Bank of offered request |
| deq_row_o | output | ROW_W | Row of offered request |
| deq_col_o | output | COL_W | Column of offered request |
| deq_write_o | output | 1 | Direction of offered request |
| open_vld_i | input | NUM_BANKS | Per bank: a row is open |
| open_row_i | input | NUM_BANKS*ROW_W | Per bank open row, bank b at bits b*ROW_W upward |

## Verification
The bench uses a tiny configuration: two banks, four-row space, two columns and a four-entry pool. Collisions, equal ranks, same-address write/read pairs and starvation therefore occur thousands of times under long sweeps with varied fill and drain rates.

- A design that let a same-address read overtake its write would return stale data.
- A design that skipped the age promotion would leave a missing-row write stranded behind a stream of hits.
- A design that broke ties by slot position instead of arrival would reorder equal requests.
- A design that accepted a request when full would lose or overwrite an entry.

Each of these shows up as a wrong request on the output against an arithmetic model of the ranking rules.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // field order sets priority: starved > hit > same_dir > is_read
  typedef struct packed {
    logic starved;
    logic hit;
    logic same_dir;
    logic is_read;
  } rank_t;
endpackage

// File: rtl/sched_slot_store.sv
module sched_slot_store #(
  parameter int DEPTH     = 8,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int AGE_LIMIT = 64
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              alloc_i,
  input  logic [BANK_W-1:0]                 alloc_bank_i,
  input  logic [ROW_W-1:0]                  alloc_row_i,
  input  logic [COL_W-1:0]                  alloc_col_i,
  input  logic                              alloc_write_i,
  input  logic                              free_i,
  input  logic [DEPTH-1:0]                  free_oh_i,
  output logic [DEPTH-1:0]                  vld_o,
  output logic [DEPTH-1:0][BANK_W-1:0]      bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]       row_o,
  output logic [DEPTH-1:0][COL_W-1:0]       col_o,
  output logic [DEPTH-1:0]                  write_o,
  output logic [DEPTH-1:0][DEPTH-1:0]       older_o,
  output logic [DEPTH-1:0]                  starved_o,
  output logic                              full_o
);
  localparam int AGE_W = $clog2(AGE_LIMIT + 1);

  logic [DEPTH-1:0]            alloc_oh;
  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_o[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              v_q;
    logic [BANK_W-1:0] b_q;
    logic [ROW_W-1:0]  r_q;
    logic [COL_W-1:0]  c_q;
    logic              w_q;
    logic [AGE_W-1:0]  age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        b_q   <= '0;
        r_q   <= '0;
        c_q   <= '0;
        w_q   <= 1'b0;
        age_q <= '0;
      end else if (alloc_i && alloc_oh[i]) begin
        v_q   <= 1'b1;
        b_q   <= alloc_bank_i;
        r_q   <= alloc_row_i;
        c_q   <= alloc_col_i;
        w_q   <= alloc_write_i;
        age_q <= '0;
      end else if (free_i && free_oh_i[i]) begin
        v_q   <= 1'b0;
      end else if (v_q && age_q != AGE_W'(AGE_LIMIT)) begin
        age_q <= age_q + 1'b1;
      end
    end

    assign vld_o[i]     = v_q;
    assign bank_o[i]    = b_q;
    assign row_o[i]     = r_q;
    assign col_o[i]     = c_q;
    assign write_o[i]   = w_q;
    assign starved_o[i] = (age_q == AGE_W'(AGE_LIMIT));
  end

  // older_q[j][k]: slot j arrived before slot k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else if (alloc_i) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc_oh[k]) begin
          for (int j = 0; j < DEPTH; j++) begin
            older_q[k][j] <= 1'b0;
            older_q[j][k] <= vld_o[j];
          end
        end
      end
    end
  end

  assign older_o = older_q;
  assign full_o  = &vld_o;
endmodule

// File: rtl/sched_rank.sv
module sched_rank
  import sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10
) (
  input  logic [DEPTH-1:0]                 vld_i,
  input  logic [DEPTH-1:0][BANK_W-1:0]     bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]      row_i,
  input  logic [DEPTH-1:0][COL_W-1:0]      col_i,
  input  logic [DEPTH-1:0]                 write_i,
  input  logic [DEPTH-1:0][DEPTH-1:0]      older_i,
  input  logic [DEPTH-1:0]                 starved_i,
  input  logic [NUM_BANKS-1:0]             open_vld_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row_i,
  input  logic                             last_write_i,
  output rank_t [DEPTH-1:0]                rank_o,
  output logic [DEPTH-1:0]                 blocked_o,
  output logic [DEPTH-1:0]                 elig_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_rank
    logic hit;
    assign hit = open_vld_i[bank_i[i]] && (open_row_i[bank_i[i]] == row_i[i]);

    always_comb begin
      blocked_o[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && vld_i[j] && write_i[j] && !write_i[i] && older_i[j][i] &&
            bank_i[j] == bank_i[i] && row_i[j] == row_i[i] && col_i[j] == col_i[i])
          blocked_o[i] = 1'b1;
      end
    end

    assign elig_o[i]          = vld_i[i] && !blocked_o[i];
    assign rank_o[i].starved  = starved_i[i];
    assign rank_o[i].hit      = hit;
    assign rank_o[i].same_dir = (write_i[i] == last_write_i);
    assign rank_o[i].is_read  = !write_i[i];
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]            elig_i,
  input  rank_t [DEPTH-1:0]           rank_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
  output logic [DEPTH-1:0]            pick_oh_o,
  output logic                        any_o
);
  rank_t            best;
  logic [DEPTH-1:0] cand;

  always_comb begin
    best = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig_i[i] && rank_i[i] > best) best = rank_i[i];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cand
    assign cand[i] = elig_i[i] && (rank_i[i] == best);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      pick_oh_o[i] = cand[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && cand[j] && older_i[j][i]) pick_oh_o[i] = 1'b0;
      end
    end
  end

  assign any_o = |elig_i;
endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
  import sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int AGE_LIMIT = 64,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        enq_valid_i,
  output logic                        enq_ready_o,
  input  logic [BANK_W-1:0]           enq_bank_i,
  input  logic [ROW_W-1:0]            enq_row_i,
  input  logic [COL_W-1:0]            enq_col_i,
  input  logic                        enq_write_i,
  output logic                        deq_valid_o,
  input  logic                        deq_ready_i,
  output logic [BANK_W-1:0]           deq_bank_o,
  output logic [ROW_W-1:0]            deq_row_o,
  output logic [COL_W-1:0]            deq_col_o,
  output logic                        deq_write_o,
  input  logic [NUM_BANKS-1:0]        open_vld_i,
  input  logic [NUM_BANKS*ROW_W-1:0]  open_row_i
);
  logic [DEPTH-1:0]                 slot_vld;
  logic [DEPTH-1:0][BANK_W-1:0]     slot_bank;
  logic [DEPTH-1:0][ROW_W-1:0]      slot_row;
  logic [DEPTH-1:0][COL_W-1:0]      slot_col;
  logic [DEPTH-1:0]                 slot_write;
  logic [DEPTH-1:0][DEPTH-1:0]      older;
  logic [DEPTH-1:0]                 starved_vec;
  logic [DEPTH-1:0]                 hit_vec;
  logic [DEPTH-1:0]                 blocked_vec;
  logic [DEPTH-1:0]                 elig_vec;
  logic [DEPTH-1:0]                 pick_oh;
  rank_t [DEPTH-1:0]                rank_vec;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row_arr;
  logic                             full;
  logic                             any;
  logic                             enq_fire;
  logic                             deq_fire;
  logic                             last_write_q;

  assign open_row_arr = open_row_i;
  assign enq_ready_o  = !full;
  assign enq_fire     = enq_valid_i && !full;
  assign deq_valid_o  = any;
  assign deq_fire     = any && deq_ready_i;

  sched_slot_store #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_LIMIT(AGE_LIMIT)
  ) store_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (enq_fire),
    .alloc_bank_i (enq_bank_i),
    .alloc_row_i  (enq_row_i),
    .alloc_col_i  (enq_col_i),
    .alloc_write_i(enq_write_i),
    .free_i       (deq_fire),
    .free_oh_i    (pick_oh),
    .vld_o        (slot_vld),
    .bank_o       (slot_bank),
    .row_o        (slot_row),
    .col_o        (slot_col),
    .write_o      (slot_write),
    .older_o      (older),
    .starved_o    (starved_vec),
    .full_o       (full)
  );

  sched_rank #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) rank_i (
    .vld_i       (slot_vld),
    .bank_i      (slot_bank),
    .row_i       (slot_row),
    .col_i       (slot_col),
    .write_i     (slot_write),
    .older_i     (older),
    .starved_i   (starved_vec),
    .open_vld_i  (open_vld_i),
    .open_row_i  (open_row_arr),
    .last_write_i(last_write_q),
    .rank_o      (rank_vec),
    .blocked_o   (blocked_vec),
    .elig_o      (elig_vec)
  );

  sched_pick #(.DEPTH(DEPTH)) pick_i (
    .elig_i   (elig_vec),
    .rank_i   (rank_vec),
    .older_i  (older),
    .pick_oh_o(pick_oh),
    .any_o    (any)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit_vec[i] = rank_vec[i].hit;
  end

  always_comb begin
    deq_bank_o  = '0;
    deq_row_o   = '0;
    deq_col_o   = '0;
    deq_write_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick_oh[i]) begin
        deq_bank_o  = deq_bank_o  | slot_bank[i];
        deq_row_o   = deq_row_o   | slot_row[i];
        deq_col_o   = deq_col_o   | slot_col[i];
        deq_write_o = deq_write_o | slot_write[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_write_q <= 1'b0;
    else if (deq_fire) last_write_q <= deq_write_o;
  end
endmodule

// File: rtl/dram_req_sched_chk.sv
module dram_req_sched_chk #(
  parameter int DEPTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enq_ready_o,
  input logic             deq_valid_o,
  input logic             deq_ready_i,
  input logic [DEPTH-1:0] slot_vld,
  input logic [DEPTH-1:0] pick_oh,
  input logic [DEPTH-1:0] elig_vec,
  input logic [DEPTH-1:0] blocked_vec,
  input logic [DEPTH-1:0] starved_vec,
  input logic [DEPTH-1:0] hit_vec
);
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enq_ready_o && !(deq_valid_o && deq_ready_i)) |=> !enq_ready_o); // R2
  AST_HIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && (starved_vec & elig_vec) == '0 && (hit_vec & elig_vec) != '0)
      |-> (pick_oh & hit_vec) != '0); // R3
  AST_SINGLE_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o |-> ($countones(pick_oh) == 1 && (pick_oh & ~elig_vec) == '0)); // R6
  AST_STARVED_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && (starved_vec & elig_vec) != '0) |-> (pick_oh & starved_vec) != '0); // R7
  AST_NO_PASS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_oh & blocked_vec) == '0); // R8
  AST_HELD_UNTIL_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i) |=> deq_valid_o); // R9
  AST_OFFER_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld != '0) |-> deq_valid_o); // R9
endmodule

bind dram_req_sched dram_req_sched_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enq_ready_o(enq_ready_o),
  .deq_valid_o(deq_valid_o),
  .deq_ready_i(deq_ready_i),
  .slot_vld   (slot_vld),
  .pick_oh    (pick_oh),
  .elig_vec   (elig_vec),
  .blocked_vec(blocked_vec),
  .starved_vec(starved_vec),
  .hit_vec    (hit_vec)
);

// File: tb/dram_req_sched_tb_top.sv
module dram_req_sched_tb_top;
  localparam int DP = 4;
  localparam int NB = 2;
  localparam int BW = 1;
  localparam int RW = 2;
  localparam int CW = 1;
  localparam int AL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          enq_valid = 1'b0, enq_write = 1'b0, deq_ready = 1'b0;
  logic [BW-1:0] enq_bank = '0;
  logic [RW-1:0] enq_row = '0;
  logic [CW-1:0] enq_col = '0;
  logic          enq_ready, deq_valid, deq_write;
  logic [BW-1:0] deq_bank;
  logic [RW-1:0] deq_row;
  logic [CW-1:0] deq_col;
  logic [NB-1:0] open_vld = '0;
  logic [NB*RW-1:0] open_row = '0;

  dram_req_sched #(.DEPTH(DP), .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .AGE_LIMIT(AL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready),
    .enq_bank_i(enq_bank), .enq_row_i(enq_row), .enq_col_i(enq_col), .enq_write_i(enq_write),
    .deq_valid_o(deq_valid), .deq_ready_i(deq_ready),
    .deq_bank_o(deq_bank), .deq_row_o(deq_row), .deq_col_o(deq_col), .deq_write_o(deq_write),
    .open_vld_i(open_vld), .open_row_i(open_row)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference pool
  bit m_v[DP];
  int m_bank[DP], m_row[DP], m_col[DP], m_wr[DP], m_age[DP], m_seq[DP];
  int seq_ctr = 0;
  int m_last = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // returns winning model slot (-1 if none) and the rule that decided it
  task automatic predict(output int win, output string tag);
    int  key[DP];
    bit  el[DP];
    bit  blk_any;
    int  best, ncand, diff, hit, b;
    blk_any = 0; best = -1; win = -1; ncand = 0; diff = 0;
    for (int i = 0; i < DP; i++) begin
      el[i] = m_v[i];
      if (m_v[i] && m_wr[i] == 0)
        for (int j = 0; j < DP; j++)
          if (m_v[j] && m_wr[j] == 1 && m_seq[j] < m_seq[i] && m_bank[j] == m_bank[i] &&
              m_row[j] == m_row[i] && m_col[j] == m_col[i]) begin
            el[i] = 0; blk_any = 1;
          end
      b   = m_bank[i];
      hit = (open_vld[b] && int'(open_row[b*RW +: RW]) == m_row[i]) ? 1 : 0;
      key[i] = (m_age[i] >= AL ? 8 : 0) + hit * 4 + (m_wr[i] == m_last ? 2 : 0) + (m_wr[i] == 0 ? 1 : 0);
      if (el[i] && key[i] > best) best = key[i];
    end
    for (int i = 0; i < DP; i++)
      if (el[i]) begin
        if (key[i] == best) begin
          ncand++;
          if (win < 0 || m_seq[i] < m_seq[win]) win = i;
        end else diff |= key[i] ^ best;
      end
    if (blk_any) tag = "R8";
    else if (diff >= 8) tag = "R7";
    else if (diff >= 4) tag = "R3";
    else if (diff >= 2) tag = "R4";
    else if (diff >= 1) tag = "R5";
    else if (ncand > 1) tag = "R6";
    else tag = "R9";
  endtask

  task automatic run_phase(input int cycles, input int p_enq, input int p_deq);
    for (int c = 0; c < cycles; c++) begin
      int    win, cnt, slot;
      string tag;
      bit    e_fire, d_fire;
      @(negedge clk);
      enq_valid = ($urandom_range(0, 99) < p_enq);
      enq_bank  = BW'($urandom_range(0, NB - 1));
      enq_row   = RW'($urandom_range(0, 3));
      enq_col   = CW'($urandom_range(0, 1));
      enq_write = $urandom_range(0, 1) == 1;
      deq_ready = ($urandom_range(0, 99) < p_deq);
      open_vld  = NB'($urandom_range(0, 3));
      open_row  = (NB*RW)'($urandom_range(0, 15));
      #1;
      cnt = 0;
      for (int i = 0; i < DP; i++) cnt += m_v[i];
      check("R2 enq_ready", int'(enq_ready), (cnt < DP) ? 1 : 0);
      predict(win, tag);
      check("R9 deq_valid", int'(deq_valid), (win >= 0) ? 1 : 0);
      if (win >= 0) begin
        check({tag, " bank"},  int'(deq_bank),  m_bank[win]);
        check({tag, " row"},   int'(deq_row),   m_row[win]);
        check({tag, " col"},   int'(deq_col),   m_col[win]);
        check({tag, " write"}, int'(deq_write), m_wr[win]);
      end
      e_fire = enq_valid && (cnt < DP);
      d_fire = (win >= 0) && deq_ready;
      // advance model to the next clock edge
      if (d_fire) begin
        m_v[win] = 0;
        m_last   = m_wr[win];
      end
      for (int i = 0; i < DP; i++) if (m_v[i]) m_age[i]++;
      if (e_fire) begin
        slot = -1;
        for (int i = DP - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        m_v[slot]    = 1;
        m_bank[slot] = int'(enq_bank);
        m_row[slot]  = int'(enq_row);
        m_col[slot]  = int'(enq_col);
        m_wr[slot]   = int'(enq_write);
        m_age[slot]  = 0;
        m_seq[slot]  = seq_ctr++;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < DP; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 deq_valid after reset", int'(deq_valid), 0);
    check("R1 enq_ready after reset", int'(enq_ready), 1);
    for (int r = 0; r < 3; r++) begin
      run_phase(1200, 70, 50);
      run_phase(200, 90, 0);   // fill, refuse, age to starvation
      run_phase(300, 60, 20);  // long waits under pressure
      run_phase(600, 30, 90);  // drain toward empty
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule